// File: doc/BRIEF.md
# Card-Detect Latch Status Register

This block is a small register file on a word-addressed bus that sits next to a removable memory card slot. It takes two level inputs from the slot: a write-protect level and a card-present level. It folds them into one status word. The write-protect bit is a live copy of its input, refreshed on every clock edge. The card bit is sticky: any cycle with the card-present input high sets it, and it stays set after the input drops.

The sticky card bit drives an interrupt line. Software services the interrupt by reading the status word. It then acknowledges the event by writing a one into the card bit position of that word. Writes that carry a zero in that position leave the bit alone. The register file also returns two fixed constants, an identification word and a decode word. It has one reserved word that reads as zero and silently absorbs writes.

Reads are combinational from the word address. Writes take effect at the clock edge on which the write strobe is high.

Top module: `cdl_regblock`

## Requirements
- R1: Word index 0 reads the identification constant 0x41034003.
- R2: Word index 3 reads the decode constant 0x00000011.
- R3: Word index 1 reads zero, and a write to word index 1 changes no readable state and does not change the interrupt.
- R4: Bit 0 of the status word (word index 2) equals the write-protect input sampled at the most recent clock edge, and writes do not change it.
- R5: Bit 3 of the status word is set at any clock edge where the card-present input is high, and it stays set after that input falls.
- R6: A write to word index 2 with write-data bit 3 at 1 clears status bit 3 at that edge. A write with write-data bit 3 at 0 leaves it unchanged.
- R7: When a clearing write and a high card-present input occur at the same edge, status bit 3 ends up set.
- R8: The interrupt output always equals status bit 3.
- R9: Word indices 4 and above read zero. Status bits other than 0 and 3 read zero.
- R10: A synchronous active-high reset clears both status bits and the interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Word index of the access |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| wprot_i | input | 1 | Write-protect level from the card slot |
| card_in_i | input | 1 | Card-present level from the card slot |
| irq_o | output | 1 | Card event interrupt, high while the sticky bit is set |

## Verification
Constant and reserved words are combinational, so they are checked a settling delay after the address changes, inside the same cycle. Status bits and the interrupt register at one rising edge. The bench therefore holds each stimulus and write for exactly one edge, then moves the address to the status word at the following falling edge and samples there. This sampling point reflects exactly the state produced by that one edge. The same-edge set/clear collision and the reset that wipes a pending event are handled the same way, so each result is compared in the first cycle in which it is due.

// File: rtl/cdl_pkg.sv
package cdl_pkg;

    localparam int DATA_W = 32;

    // Word indices; the status index and bit positions are software-visible behaviour
    localparam int IDX_ID     = 0;
    localparam int IDX_RSVD   = 1;
    localparam int IDX_STATUS = 2;
    localparam int IDX_DECODE = 3;

    localparam int WP_BIT  = 0;
    localparam int CIN_BIT = 3;

    localparam logic [DATA_W-1:0] ID_WORD     = 32'h4103_4003;
    localparam logic [DATA_W-1:0] DECODE_WORD = 32'h0000_0011;

    typedef struct packed {
        logic cin;   // sticky card event
        logic wp;    // live write-protect copy
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_status(input stat_t s);
        logic [DATA_W-1:0] r;
        r          = '0;
        r[WP_BIT]  = s.wp;
        r[CIN_BIT] = s.cin;
        return r;
    endfunction

endpackage

// File: rtl/cdl_status_latch.sv
module cdl_status_latch
    import cdl_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  wprot_i,
    input  logic  card_in_i,
    input  logic  clr_req_i,
    output stat_t stat_o
);

    stat_t stat_q;
    stat_t stat_d;

    always_comb begin
        stat_d.wp = wprot_i;
        // set dominates acknowledge
        if (card_in_i)
            stat_d.cin = 1'b1;
        else if (clr_req_i)
            stat_d.cin = 1'b0;
        else
            stat_d.cin = stat_q.cin;
    end

    always_ff @(posedge clk) begin
        if (rst)
            stat_q <= '0;
        else
            stat_q <= stat_d;
    end

    assign stat_o = stat_q;

    // R5: a high card input leaves the sticky bit set (covers R7 collision too)
    assert_set_R5: assert property (@(posedge clk) disable iff (rst)
        card_in_i |=> stat_q.cin);

    // R5: without an acknowledge the bit does not drop
    assert_keep_R5: assert property (@(posedge clk) disable iff (rst)
        (stat_q.cin && !clr_req_i) |=> stat_q.cin);

    // R6: acknowledge with no new event clears
    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        (clr_req_i && !card_in_i) |=> !stat_q.cin);

    // R4: write-protect bit tracks the input one edge later
    assert_wp_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q.wp == $past(wprot_i)));

endmodule

// File: rtl/cdl_read_mux.sv
module cdl_read_mux
    import cdl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  stat_t             stat_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        if (addr_i == ADDR_W'(IDX_ID))
            rdata_o = ID_WORD;
        else if (addr_i == ADDR_W'(IDX_STATUS))
            rdata_o = pack_status(stat_i);
        else if (addr_i == ADDR_W'(IDX_DECODE))
            rdata_o = DECODE_WORD;
        else
            rdata_o = '0;   // reserved word and undefined indices
    end

endmodule

// File: rtl/cdl_regblock.sv
module cdl_regblock
    import cdl_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              wprot_i,
    input  logic              card_in_i,
    output logic              irq_o
);

    localparam logic [ADDR_W-1:0] STATUS_ADDR = ADDR_W'(IDX_STATUS);

    stat_t status;
    logic  ack_req;
    logic  unused_wdata_bits;

    assign ack_req = bus_wr && (bus_addr == STATUS_ADDR) && bus_wdata[CIN_BIT];
    assign unused_wdata_bits = ^{bus_wdata[DATA_W-1:CIN_BIT+1], bus_wdata[CIN_BIT-1:0]};

    cdl_status_latch i_latch (
        .clk       (clk),
        .rst       (rst),
        .wprot_i   (wprot_i),
        .card_in_i (card_in_i),
        .clr_req_i (ack_req),
        .stat_o    (status)
    );

    cdl_read_mux #(.ADDR_W(ADDR_W)) i_mux (
        .addr_i  (bus_addr),
        .stat_i  (status),
        .rdata_o (bus_rdata)
    );

    assign irq_o = status.cin;

    // R8: interrupt agrees with the status word seen on the bus
    assert_irq_match_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == STATUS_ADDR) |-> (bus_rdata[CIN_BIT] == irq_o));

    // R8/R5: interrupt only rises after a card event
    assert_irq_src_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(card_in_i));

    // R9: indices past the decode word read zero
    assert_undef_zero_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr > ADDR_W'(IDX_DECODE)) |-> (bus_rdata == '0));

    // R3: reserved word reads zero
    assert_rsvd_zero_R3: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(IDX_RSVD)) |-> (bus_rdata == '0));

endmodule

// File: tb/test_cdl_regblock.sv
module test_cdl_regblock;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 4;
    localparam int NVEC = 10;

    // {wr, addr[3:0], wdata[7:0], wp, cin, exp_status[3:0], exp_irq}
    localparam logic [19:0] VEC [NVEC] = '{
        {1'b0, 4'd0, 8'h00, 1'b1, 1'b0, 4'h1, 1'b0},  // R4 wp follows
        {1'b0, 4'd0, 8'h00, 1'b0, 1'b1, 4'h8, 1'b1},  // R5 set
        {1'b0, 4'd0, 8'h00, 1'b0, 1'b0, 4'h8, 1'b1},  // R5 sticky
        {1'b1, 4'd2, 8'h01, 1'b1, 1'b0, 4'h9, 1'b1},  // R6 bit3=0, R4 bit0 from input
        {1'b1, 4'd2, 8'hF7, 1'b0, 1'b0, 4'h8, 1'b1},  // R6 bit3=0 no clear
        {1'b1, 4'd1, 8'hFF, 1'b0, 1'b0, 4'h8, 1'b1},  // R3 reserved write ignored
        {1'b1, 4'd2, 8'h08, 1'b0, 1'b1, 4'h8, 1'b1},  // R7 set beats clear
        {1'b1, 4'd2, 8'h08, 1'b0, 1'b0, 4'h0, 1'b0},  // R6 clear
        {1'b1, 4'd2, 8'h09, 1'b1, 1'b0, 4'h1, 1'b0},  // R4 write does not touch bit0
        {1'b1, 4'd0, 8'hFF, 1'b0, 1'b1, 4'h8, 1'b1}   // R1 word0 write, R5 set again
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          wprot_i = 1'b0;
    logic          card_in_i = 1'b0;
    logic          irq_o;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdl_regblock #(.ADDR_W(AW)) i_cdl_regblock (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .wprot_i   (wprot_i),
        .card_in_i (card_in_i),
        .irq_o     (irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic read_word(input int idx, input string req, input logic [31:0] exp);
        bus_addr = AW'(idx);
        #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R10 reset state
        read_word(2, "R10 status after reset", 32'h0);
        check("R10 irq after reset", {31'b0, irq_o}, 32'h0);

        // R1 R2 R3 R9 constant and undefined words
        read_word(0, "R1 id word", 32'h4103_4003);
        read_word(3, "R2 decode word", 32'h0000_0011);
        read_word(1, "R3 reserved reads zero", 32'h0);
        read_word(4, "R9 index 4", 32'h0);
        read_word(9, "R9 index 9", 32'h0);
        read_word(15, "R9 index 15", 32'h0);

        // table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [19:0] v;
            v = VEC[i];
            @(negedge clk);
            bus_wr    = v[19];
            bus_addr  = v[18:15];
            bus_wdata = {24'hFFFF_FF, v[14:7]} & {24'h0, 8'hFF} | {24'h0, v[14:7]};
            wprot_i   = v[6];
            card_in_i = v[5];
            @(posedge clk);
            @(negedge clk);
            bus_wr = 1'b0;
            // R9 other status bits zero is covered by the full-word compare
            read_word(2, $sformatf("R4/R5/R6/R7/R9 vector %0d status", i), {28'h0, v[4:1]});
            check($sformatf("R8 vector %0d irq", i), {31'b0, irq_o}, {31'b0, v[0]});
        end

        // R3: reserved write with full ones leaves the constants and status intact
        @(negedge clk);
        card_in_i = 1'b0; wprot_i = 1'b1;
        bus_wr = 1'b1; bus_addr = AW'(1); bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        read_word(1, "R3 reserved still zero", 32'h0);
        read_word(2, "R3 status unchanged", 32'h9);
        read_word(0, "R1 id after writes", 32'h4103_4003);

        // R6 upper bits set in an ack still clear the sticky bit
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = AW'(2); bus_wdata = 32'hFFFF_FFFF;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        read_word(2, "R6 full-ones ack", 32'h1);
        check("R8 irq after full-ones ack", {31'b0, irq_o}, 32'h0);

        // R10 reset wipes a pending event
        @(negedge clk);
        card_in_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        card_in_i = 1'b0;
        check("R5 event pending before reset", {31'b0, irq_o}, 32'h1);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        read_word(2, "R10 status cleared by reset", 32'h0);
        check("R10 irq cleared by reset", {31'b0, irq_o}, 32'h0);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        read_word(2, "R4 wp after reset release", 32'h1);

        finish_run();
    end

endmodule